// File: doc/BRIEF.md
# Control endpoint mode and byte-count register arbiter

This block owns the two per-endpoint registers of control endpoint 0 in a low-speed USB device: a mode register and a byte-count register. Two agents reach them. The CPU uses I/O read and write strobes with an address and a data byte. The serial interface engine reports transaction events: a token with its kind (setup, IN or OUT), the start of the data phase, the start of the returned ACK, and the end of the transaction together with a flag saying whether it ended with an ACK.

The engine records the kind of the most recent token in sticky status bits and flags acknowledged transactions. Once the engine has written status, the CPU cannot overwrite the low seven mode bits until it has read the register, so firmware cannot silently lose an update. A setup in progress pins the setup bit high and also guards two windows of the data buffer against CPU writes, so that firmware filling an IN buffer cannot corrupt the arriving setup packet. The buffer memory itself lives outside this block; only the inhibit signal comes from here.

Top module: `ep0_mode_arb`

## Requirements
- R1: After a cycle with rst_n low at a clock edge, the mode register, the byte-count register, the lock, the setup hold and the read data are all zero.
- R2: Mode bits 7, 6 and 5 record setup, IN and OUT. At a transaction end the bit for the latched token kind (kind codes: 1 setup, 2 IN, 3 OUT, 0 none) is set. None of bits 7:5 is cleared except by a CPU write to the mode register.
- R3: A transaction end with the acked flag high sets mode bit 4; without it bit 4 is left unchanged.
- R4: A data-phase start while the latched token is a setup sets mode bit 7 and starts a hold on that bit. While the hold is active, CPU writes leave bit 7 at 1. The hold ends only at a CPU read of the mode register made after the next ACK start or transaction end.
- R5: A transaction end sets a lock. While locked, CPU writes to the mode register leave bits 6:0 unchanged. A CPU read of the mode register clears the lock at the same clock edge that captures the read data, so a write in the next cycle takes effect.
- R6: The buffer inhibit output is high exactly when the CPU write strobe is high, mode bit 7 is 1 and the address lies in 0xE0 to 0xE7 or 0xF8 to 0xFF. The output is combinational in the current cycle.
- R7: A CPU write to the byte-count register stores bit 7 (data toggle, 0 = DATA0), bit 6 (data valid) and bits 3:0 as the count, with values above 8 stored as 8. Bits 5:4 read back as 0.
- R8: When a transaction end and a CPU write to the mode register fall in the same cycle, the write is discarded entirely and the lock is set. This holds even when a mode read falls in the same cycle.
- R9: A CPU read returns, one clock edge later on cpu_rdata, the value held before that edge: address 0x12 is the mode register, 0x11 is the byte-count register, and any other address reads 0. The read data holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd | input | 1 | CPU I/O read strobe |
| cpu_wr | input | 1 | CPU I/O write strobe |
| cpu_addr | input | 8 | CPU I/O or buffer address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered read data |
| eng_tok_valid | input | 1 | Engine saw a token |
| eng_tok_kind | input | 2 | Token kind: 1 setup, 2 IN, 3 OUT |
| eng_data_start | input | 1 | Data phase begins |
| eng_ack_start | input | 1 | Returned ACK begins |
| eng_xact_end | input | 1 | Transaction completed |
| eng_acked | input | 1 | Transaction ended with ACK (valid with eng_xact_end) |
| buf_wr_inhibit | output | 1 | Blocks the current CPU buffer write |

## Verification
The bench builds the block with its default parameters: an 8-bit address, register addresses 0x11 and 0x12, two guarded windows of eight bytes at 0xE0 and 0xF8, and a count limit of 8. With these values every address is reachable from random stimulus, so the edges of both windows and their neighbours 0xE8 and 0xF7 are covered. Counts of 9 to 15 cover saturation. Directed sequences force the collisions between engine and CPU: a write during the setup hold, a write while locked, and a write and a read together with a transaction end. Random engine strobes then mix tokens, phases and collisions in orders a real engine would not produce.

// File: rtl/ep0_arb_pkg.sv
// Shared types and field positions for the endpoint-0 register arbiter.
// Assumes an 8-bit register data path.
package ep0_arb_pkg;
    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_SETUP = 2'd1,
        TK_IN    = 2'd2,
        TK_OUT   = 2'd3
    } tok_kind_t;

    localparam int REG_W   = 8;
    localparam int B_SETUP = 7;
    localparam int B_IN    = 6;
    localparam int B_OUT   = 5;
    localparam int B_ACK   = 4;
endpackage

// File: rtl/ep0_token_track.sv
// Tracks the latched token kind, the setup force window (data start to
// ACK start) and the setup hold, which survives until the CPU reads the
// mode register after the force window. Assumes the engine pulses each
// event for one cycle.
module ep0_token_track
    import ep0_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tok_valid,
    input  tok_kind_t tok_kind,
    input  logic      data_start,
    input  logic      ack_start,
    input  logic      xact_end,
    input  logic      rd_mode,
    output tok_kind_t pend_kind,
    output logic      setup_ds,
    output logic      force_q,
    output logic      hold_q
);
    assign setup_ds = data_start && (pend_kind == TK_SETUP);

    // Latch the kind of the token in flight; a new token overrides the clear at transaction end.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_kind <= TK_NONE;
        else if (tok_valid)  pend_kind <= tok_kind;
        else if (xact_end)   pend_kind <= TK_NONE;
    end

    // Force window: from setup data start until ACK start or transaction end.
    always_ff @(posedge clk) begin
        if (!rst_n)                      force_q <= 1'b0;
        else if (ack_start || xact_end)  force_q <= 1'b0;
        else if (setup_ds)               force_q <= 1'b1;
    end

    // Hold: released by the first mode read after the force window.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hold_q <= 1'b0;
        else if (setup_ds)              hold_q <= 1'b1;
        else if (rd_mode && !force_q)   hold_q <= 1'b0;
    end

    // R4: the force window never exists without the hold.
    p_force_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_q |-> hold_q);
endmodule

// File: rtl/ep0_mode_reg.sv
// Mode register with sticky token bits, acknowledge bit and the write lock.
// Engine transaction-end updates take priority over CPU writes in the
// same cycle. Assumes rd_mode/wr_mode are already address-decoded.
module ep0_mode_reg
    import ep0_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mode,
    input  logic             rd_mode,
    input  logic [REG_W-1:0] wdata,
    input  logic             xact_end,
    input  logic             acked,
    input  tok_kind_t        pend_kind,
    input  logic             setup_ds,
    input  logic             hold_q,
    output logic [REG_W-1:0] mode_q,
    output logic             lock_q
);
    logic [REG_W-1:0] mode_d;

    // Next mode value: engine end wins, else CPU write filtered by hold and lock.
    always_comb begin
        mode_d = mode_q;
        if (xact_end) begin
            case (pend_kind)
                TK_SETUP: mode_d[B_SETUP] = 1'b1;
                TK_IN:    mode_d[B_IN]    = 1'b1;
                TK_OUT:   mode_d[B_OUT]   = 1'b1;
                default:  ;
            endcase
            if (acked) mode_d[B_ACK] = 1'b1;
        end else if (wr_mode) begin
            if (!hold_q) mode_d[B_SETUP] = wdata[B_SETUP];
            if (!lock_q) mode_d[B_SETUP-1:0] = wdata[B_SETUP-1:0];
        end
        if (setup_ds) mode_d[B_SETUP] = 1'b1;
    end

    // Mode register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    // Lock: set by every engine end, cleared by a mode read.
    always_ff @(posedge clk) begin
        if (!rst_n)        lock_q <= 1'b0;
        else if (xact_end) lock_q <= 1'b1;
        else if (rd_mode)  lock_q <= 1'b0;
    end

    p_sticky_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> ((mode_q[7:5] & $past(mode_q[7:5])) == $past(mode_q[7:5])));
    p_ack_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_end && acked) |=> mode_q[B_ACK]);
    p_locked_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && wr_mode && !xact_end) |=> (mode_q[6:0] == $past(mode_q[6:0])));
    p_engine_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_end && wr_mode && pend_kind == TK_IN) |=> (mode_q[B_IN] && lock_q));
endmodule

// File: rtl/ep0_cnt_reg.sv
// Byte-count register: toggle, data-valid and a count saturated at
// MAX_CNT; reserved bits are stored as zero. CPU-written only.
module ep0_cnt_reg
    import ep0_arb_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int MAX_CNT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] MAXV  = CNT_W'(MAX_CNT);
    localparam int               RSV_W = REG_W - 2 - CNT_W;

    logic [CNT_W-1:0] cnt_sat;

    // Clamp an oversized count to the limit.
    always_comb cnt_sat = (wdata[CNT_W-1:0] > MAXV) ? MAXV : wdata[CNT_W-1:0];

    // Register storage; reserved field forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= {wdata[REG_W-1:REG_W-2], {RSV_W{1'b0}}, cnt_sat};
    end

    p_count_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[CNT_W-1:0] <= MAXV) && (cnt_q[REG_W-3:CNT_W] == '0));
endmodule

// File: rtl/ep0_buf_guard.sv
// Raises the buffer write inhibit when a CPU write targets one of the
// guarded address windows while the setup bit is set. Assumes windows do
// not need to be aligned.
module ep0_buf_guard #(
    parameter int                        AW       = 8,
    parameter int                        NWIN     = 2,
    parameter int                        WIN_SIZE = 8,
    parameter logic [NWIN-1:0][AW-1:0]   WIN_BASE = {8'hF8, 8'hE0}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic          setup_bit,
    output logic          inhibit
);
    logic [NWIN-1:0] hit;

    // One range compare per window, widened by a bit to avoid wrap.
    for (genvar i = 0; i < NWIN; i++) begin : g_win
        localparam logic [AW:0] LO = {1'b0, WIN_BASE[i]};
        localparam logic [AW:0] HI = LO + (AW+1)'(WIN_SIZE);
        assign hit[i] = ({1'b0, cpu_addr} >= LO) && ({1'b0, cpu_addr} < HI);
    end

    assign inhibit = cpu_wr && setup_bit && (|hit);

    p_inhibit_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> (cpu_wr && setup_bit));
endmodule

// File: rtl/ep0_mode_arb.sv
// Top of the endpoint-0 register arbiter: decodes CPU accesses, joins the
// token tracker, mode and count registers, buffer guard and read mux.
// Assumes the register addresses lie outside the guarded windows.
module ep0_mode_arb
    import ep0_arb_pkg::*;
#(
    parameter int            AW        = 8,
    parameter logic [AW-1:0] MODE_ADDR = 8'h12,
    parameter logic [AW-1:0] CNT_ADDR  = 8'h11,
    parameter int            CNT_W     = 4,
    parameter int            MAX_CNT   = 8,
    parameter int            WIN_SIZE  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             eng_tok_valid,
    input  logic [1:0]       eng_tok_kind,
    input  logic             eng_data_start,
    input  logic             eng_ack_start,
    input  logic             eng_xact_end,
    input  logic             eng_acked,
    output logic             buf_wr_inhibit
);
    logic             rd_mode, wr_mode, rd_cnt, wr_cnt;
    logic             setup_ds, force_q, hold_q, lock_q;
    tok_kind_t        pend_kind;
    logic [REG_W-1:0] mode_q, cnt_q;

    assign rd_mode = cpu_rd && (cpu_addr == MODE_ADDR);
    assign wr_mode = cpu_wr && (cpu_addr == MODE_ADDR);
    assign rd_cnt  = cpu_rd && (cpu_addr == CNT_ADDR);
    assign wr_cnt  = cpu_wr && (cpu_addr == CNT_ADDR);

    ep0_token_track u_track (
        .clk(clk), .rst_n(rst_n), .tok_valid(eng_tok_valid),
        .tok_kind(tok_kind_t'(eng_tok_kind)), .data_start(eng_data_start),
        .ack_start(eng_ack_start), .xact_end(eng_xact_end), .rd_mode(rd_mode),
        .pend_kind(pend_kind), .setup_ds(setup_ds), .force_q(force_q), .hold_q(hold_q)
    );

    ep0_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .rd_mode(rd_mode),
        .wdata(cpu_wdata), .xact_end(eng_xact_end), .acked(eng_acked),
        .pend_kind(pend_kind), .setup_ds(setup_ds), .hold_q(hold_q),
        .mode_q(mode_q), .lock_q(lock_q)
    );

    ep0_cnt_reg #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wdata(cpu_wdata), .cnt_q(cnt_q)
    );

    ep0_buf_guard #(.AW(AW), .NWIN(2), .WIN_SIZE(WIN_SIZE)) u_guard (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .setup_bit(mode_q[B_SETUP]), .inhibit(buf_wr_inhibit)
    );

    // Registered read data: captures the pre-edge register value on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      cpu_rdata <= '0;
        else if (rd_mode) cpu_rdata <= mode_q;
        else if (rd_cnt)  cpu_rdata <= cnt_q;
        else if (cpu_rd)  cpu_rdata <= '0;
    end

    p_force_sets_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_q |-> mode_q[B_SETUP]);
    p_read_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode && !eng_xact_end) |=> !lock_q);
    p_read_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt |=> (cpu_rdata == $past(cnt_q)));
endmodule

// File: tb/ep0_mode_arb_test.sv
// Bench for ep0_mode_arb: directed corner cases, then seeded random traffic,
// all checked against a requirement-level model kept in the bench.
module ep0_mode_arb_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd = 0, wr = 0, tv = 0, ds = 0, as_ = 0, xe = 0, ack = 0;
    logic [7:0] addr = 0, wd = 0;
    logic [1:0] tk = 0;
    logic [7:0] rdata;
    logic       inh;

    int tests = 0, fails = 0;
    bit done = 0;

    localparam logic [7:0] A_MODE = 8'h12, A_CNT = 8'h11;

    // Requirement-level model state
    logic [7:0] m_mode = 0, m_cnt = 0, m_rdata = 0;
    logic       m_lock = 0, m_hold = 0, m_force = 0;
    logic [1:0] m_pend = 0;

    always #5 clk = ~clk;

    ep0_mode_arb uut (
        .clk(clk), .rst_n(rst_n), .cpu_rd(rd), .cpu_wr(wr), .cpu_addr(addr),
        .cpu_wdata(wd), .cpu_rdata(rdata), .eng_tok_valid(tv), .eng_tok_kind(tk),
        .eng_data_start(ds), .eng_ack_start(as_), .eng_xact_end(xe),
        .eng_acked(ack), .buf_wr_inhibit(inh)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_inhibit();
        return wr && m_mode[7] && ((addr >= 8'hE0 && addr <= 8'hE7) || addr >= 8'hF8);
    endfunction

    function automatic logic [7:0] sat_cnt(input logic [7:0] v);
        return {v[7:6], 2'b00, (v[3:0] > 4'd8) ? 4'd8 : v[3:0]};
    endfunction

    // Advance the model by one clock edge using the driven inputs.
    task automatic model_edge();
        logic       sds, rdm, wrm;
        logic [7:0] nm;
        sds = ds && (m_pend == 2'd1);
        rdm = rd && addr == A_MODE;
        wrm = wr && addr == A_MODE;
        nm = m_mode;
        if (xe) begin
            if (m_pend == 2'd1) nm[7] = 1;
            if (m_pend == 2'd2) nm[6] = 1;
            if (m_pend == 2'd3) nm[5] = 1;
            if (ack) nm[4] = 1;
        end else if (wrm) begin
            if (!m_hold) nm[7] = wd[7];
            if (!m_lock) nm[6:0] = wd[6:0];
        end
        if (sds) nm[7] = 1;
        if (rd) m_rdata = rdm ? m_mode : (addr == A_CNT) ? m_cnt : 8'h00;
        if (wr && addr == A_CNT) m_cnt = sat_cnt(wd);
        m_lock  = xe ? 1'b1 : (rdm ? 1'b0 : m_lock);
        m_hold  = sds ? 1'b1 : ((rdm && !m_force) ? 1'b0 : m_hold);
        m_force = (as_ || xe) ? 1'b0 : (sds ? 1'b1 : m_force);
        m_pend  = tv ? tk : (xe ? 2'd0 : m_pend);
        m_mode  = nm;
    endtask

    task automatic idle();
        rd = 0; wr = 0; tv = 0; ds = 0; as_ = 0; xe = 0; ack = 0;
    endtask

    // One cycle: inputs are set at the negedge; check inhibit, take edge, check read data.
    task automatic tick(input string tag);
        #1;
        if (wr) check("R6 inhibit", {7'd0, inh}, {7'd0, exp_inhibit()});
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rd) check(tag, rdata, m_rdata);
        idle();
    endtask

    task automatic rd_reg(input logic [7:0] a, input string tag);
        idle(); rd = 1; addr = a; tick(tag);
    endtask
    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        idle(); wr = 1; addr = a; wd = d; tick("R6 write");
    endtask
    task automatic token(input logic [1:0] k);
        idle(); tv = 1; tk = k; tick("R2 token");
    endtask
    task automatic dstart(); idle(); ds = 1; tick("R4 ds"); endtask
    task automatic astart(); idle(); as_ = 1; tick("R4 as"); endtask
    task automatic xend(input logic a); idle(); xe = 1; ack = a; tick("R2 end"); endtask
    task automatic buf_wr(input logic [7:0] a); idle(); wr = 1; addr = a; wd = 8'h55; tick("R6"); endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1 rdata", rdata, 8'h00);
        rd_reg(A_MODE, "R1 mode"); check("R1 mode lit", rdata, 8'h00);
        rd_reg(A_CNT, "R1 cnt");   check("R1 cnt lit", rdata, 8'h00);
        // R7: saturation and reserved bits
        wr_reg(A_CNT, 8'hFF); rd_reg(A_CNT, "R7 sat"); check("R7 sat lit", rdata, 8'hC8);
        wr_reg(A_CNT, 8'h35); rd_reg(A_CNT, "R7 rsv"); check("R7 rsv lit", rdata, 8'h05);
        wr_reg(A_CNT, 8'h48); rd_reg(A_CNT, "R7 eight"); check("R7 eight lit", rdata, 8'h48);
        // R9: other address reads zero
        rd_reg(8'h40, "R9 other"); check("R9 other lit", rdata, 8'h00);
        // R5: unlocked write, then OUT transaction with ACK locks
        wr_reg(A_MODE, 8'h0A); rd_reg(A_MODE, "R5 unlocked"); check("R5 lit", rdata, 8'h0A);
        token(2'd3); dstart(); astart(); xend(1'b1);
        wr_reg(A_MODE, 8'h00);
        rd_reg(A_MODE, "R5 locked"); check("R2 R3 out lit", rdata, 8'h3A);
        wr_reg(A_MODE, 8'h03);
        rd_reg(A_MODE, "R5 after read"); check("R5 unlock lit", rdata, 8'h03);
        // R3: NAKed IN leaves ack bit unchanged
        token(2'd2); dstart(); xend(1'b0);
        rd_reg(A_MODE, "R3 nak"); check("R3 nak lit", rdata, 8'h43);
        // R4 / R6: setup forcing, hold and buffer windows
        token(2'd1); dstart();
        buf_wr(8'hE0); buf_wr(8'hE7); buf_wr(8'hE8); buf_wr(8'hF7); buf_wr(8'hF8); buf_wr(8'hFF);
        wr_reg(A_MODE, 8'h00);
        rd_reg(A_MODE, "R4 forced"); check("R4 forced lit", rdata, 8'h80);
        wr_reg(A_MODE, 8'h00);
        rd_reg(A_MODE, "R4 still held"); check("R4 held lit", rdata, 8'h80);
        astart(); xend(1'b1);
        wr_reg(A_MODE, 8'h00);
        rd_reg(A_MODE, "R4 locked held"); check("R4 lock lit", rdata, 8'h90);
        wr_reg(A_MODE, 8'h00);
        rd_reg(A_MODE, "R4 released"); check("R4 release lit", rdata, 8'h00);
        buf_wr(8'hE3);
        // R8: transaction end collides with write and read
        token(2'd2);
        idle(); xe = 1; ack = 1; wr = 1; addr = A_MODE; wd = 8'h0F; tick("R8 collide");
        idle(); xe = 1; rd = 1; addr = A_MODE; tick("R8 read collide");
        wr_reg(A_MODE, 8'h0F);
        rd_reg(A_MODE, "R8 still locked"); check("R8 lit", rdata, 8'h50);
        // Random phase, fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            idle();
            r = $urandom % 8;
            rd = (r == 0) || (r == 1);
            wr = (r == 2) || (r == 3) || (r == 4);
            case ($urandom % 4)
                0: addr = A_MODE;
                1: addr = A_CNT;
                default: addr = 8'($urandom);
            endcase
            wd  = 8'($urandom);
            tv  = ($urandom % 6) == 0;
            tk  = 2'($urandom);
            ds  = ($urandom % 6) == 0;
            as_ = ($urandom % 8) == 0;
            xe  = ($urandom % 8) == 0;
            ack = 1'($urandom);
            tick("R9 random read");
        end
        rd_reg(A_MODE, "R2 final mode");
        rd_reg(A_CNT, "R7 final cnt");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule